// File: doc/BRIEF.md
# 4-Bit Accumulator Processor Core

This block is a compact 4-bit processor core. Each clock cycle it presents a 9-bit fetch address and takes back an 11-bit instruction word from an external program memory in the same cycle. It then executes that word in one cycle. It holds a 4-bit working register (W), the carry and zero flags, a call-mode bit, a 9-bit program counter, a two-entry return stack and 24 nibbles of general storage. The core owns a 32-address register space. Registers that belong to neighbouring timer and port logic are reached through a simple combinational read / single-cycle write bus.

There is no separate call opcode. Software sets bit 2 of the status-high register, and the next jump then pushes its return address and clears that bit. The return instruction pops the stack and also loads a 4-bit immediate into W. Conditional instructions do not branch. They mark the next fetched word as skipped, and that word then executes as a no-op.

Top module: `acc4_core`

## Requirements
- R1: While rst_n is low, the core resets the program counter, W, carry, zero, call mode, the skip state and both stack entries to 0. The first fetch after reset is from address 0.
- R2: The core executes one instruction per clock, read from imem_data at address imem_addr in the same cycle. Unless the instruction redirects it, the next fetch address is the current one plus 1, wrapping modulo 512.
- R3: An instruction whose bits [10:9] are 00 jumps: bits [8:0] become the next fetch address.
- R4: If call mode (register 4, bit 2) is set when a jump executes, the core pushes the jump's address plus 1 onto the stack and clears call mode.
- R5: The return instruction, bits [10:4] = 1001010, loads the top stack entry into the program counter and loads bits [3:0] into W.
- R6: A push moves the top entry down and discards the older entry, so only the two latest return addresses are kept. A pop copies the lower entry up and leaves the lower entry unchanged.
- R7: Register operations use the form 1 t 1 ooo aaaaa. The codes for ooo are: 000 rotate, 001 AND, 010 XOR, 011 OR, 101 load, 110 add, 111 decrement. For these codes, t=0 writes the result to W and t=1 writes it to register aaaaa. Code 100 always stores W into register aaaaa.
- R8: Add sets carry to the carry out and sets zero if the 4-bit sum is 0. AND, OR, XOR (register and immediate forms) and load update only zero. No other instruction changes a flag. Register 3 reads {0, zero, carry, 0}, and writing it loads carry from bit 1 and zero from bit 2.
- R9: Rotate right moves each bit of the operand down one place and puts 0 into bit 3. Bit 0 is dropped.
- R10: Decrement writes the operand minus 1. It skips the next instruction when that result is 0, and it changes no flag.
- R11: Bit operations use the form 0 1 s k bb aaaaa. With k=0, bit bb of register aaaaa is set (s=1) or cleared (s=0). With k=1, the next instruction is skipped when bit bb is 1 (s=1) or when it is 0 (s=0).
- R12: A skipped instruction writes no register, no flag, no stack entry and no W, and the fetch address advances by exactly 1.
- R13: Register map. Addresses 1, 5, 6 and 7 are external: reads return xreg_rdata, and writes pulse xreg_we with xreg_addr and xreg_wdata valid. Address 0 reads 0. Address 2 reads the low nibble of the program counter, and writing it redirects the next fetch to {pc[8:4], value}. Addresses 8 to 31 are internal storage.
- R14: Immediate forms 100 cccc iiii: cccc=1000 loads iiii into W, 0010 ANDs it into W, 0100 XORs it, and 0110 ORs it. Every other code of the form 100 0xxx xxxx is a no-op for the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 9 | Program memory fetch address (program counter) |
| imem_data | input | 11 | Instruction word at imem_addr, same cycle |
| xreg_addr | output | 5 | Register address of the current instruction |
| xreg_rdata | input | 4 | Read data from external registers |
| xreg_wdata | output | 4 | Write data to external registers |
| xreg_we | output | 1 | Write strobe for an external register |

## Verification
The bound checker watches control flow on every cycle. It checks that jumps land on their target, that sequential and skipped instructions advance by one, and that calls push the right return address, shift the stack and drop call mode. It also checks that returns restore the top entry and that a skipped cycle never strobes an external write. Data results cannot be checked cycle by cycle without a second datapath: ALU values, flag encodings, rotate and bit positions, decrement skips, stack overflow and the register map. The directed programs in the bench show these by storing intermediate values out through the external register bus.

// File: rtl/acc4_core.sv
module acc4_core #(
  parameter int PC_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] imem_addr,
  input  logic [10:0]     imem_data,
  output logic [4:0]      xreg_addr,
  input  logic [3:0]      xreg_rdata,
  output logic [3:0]      xreg_wdata,
  output logic            xreg_we
);

  localparam int NREG   = 32;
  localparam int RAM_LO = 8;

  logic [PC_W-1:0] pc, pc_next, stk0, stk1;
  logic [3:0]      w, rd, res, mask;
  logic            c, z, callm, skip;
  logic            wr_reg, wr_w, set_c, set_z, cy, hit;
  logic [3:0]      ram [RAM_LO:NREG-1];

  wire [10:0] ir      = imem_data;
  wire [4:0]  ra      = ir[4:0];
  wire        live    = !skip;
  wire        is_jmp  = ir[10:9] == 2'b00;
  wire        is_bit  = ir[10:9] == 2'b01;
  wire        is_misc = ir[10:8] == 3'b100;
  wire        is_alu  = ir[10] & ir[8];
  wire        is_ext  = (ra == 5'd1) || (ra[4:2] == 3'b001 && ra[1:0] != 2'b00);
  wire        is_ram  = ra >= 5'(RAM_LO);

  wire we_reg = live & wr_reg;
  wire we_w   = live & wr_w;
  wire jmp    = live & is_jmp;
  wire ret    = live & is_misc & (ir[7:4] == 4'b1010);
  wire push   = jmp & callm;

  assign imem_addr  = pc;
  assign xreg_addr  = ra;
  assign xreg_wdata = res;
  assign xreg_we    = we_reg & is_ext;
  assign mask       = 4'b0001 << ir[6:5];

  always_comb begin
    case (ra)
      5'd0:    rd = 4'd0;
      5'd2:    rd = pc[3:0];
      5'd3:    rd = {1'b0, z, c, 1'b0};
      5'd4:    rd = {1'b0, callm, 2'b00};
      default: rd = is_ext ? xreg_rdata : (is_ram ? ram[ra] : 4'd0);
    endcase
  end

  always_comb begin
    res = w; wr_reg = 1'b0; wr_w = 1'b0;
    set_c = 1'b0; set_z = 1'b0; cy = c; hit = 1'b0;
    if (is_alu) begin
      wr_reg = ir[9];
      wr_w   = !ir[9];
      case (ir[7:5])
        3'd0: res = {1'b0, rd[3:1]};
        3'd1: begin res = rd & w; set_z = 1'b1; end
        3'd2: begin res = rd ^ w; set_z = 1'b1; end
        3'd3: begin res = rd | w; set_z = 1'b1; end
        3'd4: begin res = w; wr_reg = 1'b1; wr_w = 1'b0; end
        3'd5: begin res = rd; set_z = 1'b1; end
        3'd6: begin {cy, res} = {1'b0, rd} + {1'b0, w}; set_c = 1'b1; set_z = 1'b1; end
        default: begin res = rd - 4'd1; hit = (res == 4'd0); end
      endcase
    end else if (is_bit) begin
      if (!ir[7]) begin
        res    = ir[8] ? (rd | mask) : (rd & ~mask);
        wr_reg = 1'b1;
      end else begin
        hit = (rd[ir[6:5]] == ir[8]);
      end
    end else if (is_misc) begin
      case (ir[7:4])
        4'b1000, 4'b1010: begin res = ir[3:0]; wr_w = 1'b1; end
        4'b0010: begin res = w & ir[3:0]; wr_w = 1'b1; set_z = 1'b1; end
        4'b0100: begin res = w ^ ir[3:0]; wr_w = 1'b1; set_z = 1'b1; end
        4'b0110: begin res = w | ir[3:0]; wr_w = 1'b1; set_z = 1'b1; end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (jmp)                      pc_next = PC_W'(ir[8:0]);
    else if (ret)                 pc_next = stk0;
    else if (we_reg && ra == 5'd2) pc_next = {pc[PC_W-1:4], res};
    else                          pc_next = pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; stk0 <= '0; stk1 <= '0;
      w <= 4'd0; c <= 1'b0; z <= 1'b0; callm <= 1'b0; skip <= 1'b0;
    end else begin
      pc   <= pc_next;
      skip <= live & hit;
      if (we_w) w <= res;
      if (push) begin
        stk0 <= pc + 1'b1;
        stk1 <= stk0;
      end else if (ret) begin
        stk0 <= stk1;
      end
      if (we_reg && ra == 5'd3) begin
        c <= res[1];
        z <= res[2];
      end
      if (live && set_c) c <= cy;
      if (live && set_z) z <= (res == 4'd0);
      if (push)                      callm <= 1'b0;
      else if (we_reg && ra == 5'd4) callm <= res[2];
    end
  end

  always_ff @(posedge clk) begin
    if (we_reg && is_ram) ram[ra] <= res;
  end

endmodule

// File: rtl/acc4_core_chk.sv
module acc4_core_chk #(
  parameter int PC_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] imem_addr,
  input logic [10:0]     imem_data,
  input logic            xreg_we,
  input logic            skip,
  input logic            callm,
  input logic [PC_W-1:0] stk0,
  input logic [PC_W-1:0] stk1
);

  wire jmp_now = !skip && imem_data[10:9] == 2'b00;

  a_r1_reset_pc: assert property (@(posedge clk)
    !rst_n |=> imem_addr == '0);

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip && imem_data[10] && imem_data[8] && imem_data[4:0] != 5'd2)
    |=> imem_addr == PC_W'($past(imem_addr) + 1'b1));

  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_now |=> imem_addr == PC_W'($past(imem_data[8:0])));

  a_r4_call_push: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_now && callm) |=> (stk0 == PC_W'($past(imem_addr) + 1'b1)) && !callm);

  a_r6_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_now && callm) |=> stk1 == $past(stk0));

  a_r5_return_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip && imem_data[10:4] == 7'b1001010) |=> imem_addr == $past(stk0));

  a_r12_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !xreg_we);

  a_r12_skip_pc: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> imem_addr == PC_W'($past(imem_addr) + 1'b1));

endmodule

bind acc4_core acc4_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
  .xreg_we(xreg_we), .skip(skip), .callm(callm), .stk0(stk0), .stk1(stk1)
);

// File: tb/tb_acc4_core.sv
module tb_acc4_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  imem_addr;
  logic [10:0] imem_data;
  logic [4:0]  xreg_addr;
  logic [3:0]  xreg_rdata, xreg_wdata;
  logic        xreg_we;

  logic [10:0] prog [512];
  logic [3:0]  ext_mem [8];
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_data  = prog[imem_addr];
  assign xreg_rdata = ext_mem[xreg_addr[2:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) ext_mem[i] <= 4'hF;
    end else if (xreg_we) begin
      ext_mem[xreg_addr[2:0]] <= xreg_wdata;
    end
  end

  acc4_core dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .xreg_addr(xreg_addr), .xreg_rdata(xreg_rdata), .xreg_wdata(xreg_wdata),
    .xreg_we(xreg_we)
  );

  localparam logic [10:0] NOP = 11'h400;
  localparam logic [2:0] O_RRR = 3'd0, O_AND = 3'd1, O_XOR = 3'd2, O_IOR = 3'd3,
                         O_LDR = 3'd5, O_ADD = 3'd6, O_DEC = 3'd7;

  function automatic logic [10:0] i_ldwi(input logic [3:0] v); return {7'b1001000, v}; endfunction
  function automatic logic [10:0] i_imm(input logic [3:0] cc, input logic [3:0] v); return {3'b100, cc, v}; endfunction
  function automatic logic [10:0] i_stwr(input logic [4:0] r); return {6'b111100, r}; endfunction
  function automatic logic [10:0] i_alu(input logic [2:0] o, input logic t, input logic [4:0] r);
    return {1'b1, t, 1'b1, o, r};
  endfunction
  function automatic logic [10:0] i_bit(input logic s, input logic k, input logic [1:0] b, input logic [4:0] r);
    return {2'b01, s, k, b, r};
  endfunction
  function automatic logic [10:0] i_jmp(input logic [8:0] n); return {2'b00, n}; endfunction
  function automatic logic [10:0] i_ret(input logic [3:0] v); return {7'b1001010, v}; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 512; i++) prog[i] = NOP;
  endtask

  task automatic run(input int n);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_alu_flags();
    clear_prog();
    prog[0] = i_ldwi(4'h9);  prog[1] = i_stwr(5'd8);
    prog[2] = i_ldwi(4'h8);  prog[3] = i_alu(O_ADD, 1'b0, 5'd8);
    prog[4] = i_stwr(5'd5);  prog[5] = i_alu(O_LDR, 1'b0, 5'd3);
    prog[6] = i_stwr(5'd6);  prog[7] = i_ldwi(4'h5);
    prog[8] = i_imm(4'b0100, 4'h5); prog[9] = i_alu(O_LDR, 1'b0, 5'd3);
    prog[10] = i_stwr(5'd7); prog[11] = i_alu(O_LDR, 1'b0, 5'd3);
    prog[12] = i_stwr(5'd1); prog[13] = i_jmp(9'd13);
    run(40);
    chk("R7 add into W", ext_mem[5], 4'h1);
    chk("R8 add sets carry only", ext_mem[6], 4'h2);
    chk("R8 xor zero with carry kept", ext_mem[7], 4'h6);
    chk("R8 load clears zero", ext_mem[1], 4'h2);
  endtask

  task automatic t_logic_rotate();
    clear_prog();
    prog[0] = i_ldwi(4'hC);  prog[1] = i_stwr(5'd9);
    prog[2] = i_ldwi(4'hA);  prog[3] = i_alu(O_AND, 1'b1, 5'd9);
    prog[4] = i_alu(O_IOR, 1'b0, 5'd9); prog[5] = i_alu(O_XOR, 1'b1, 5'd9);
    prog[6] = i_alu(O_LDR, 1'b0, 5'd9); prog[7] = i_stwr(5'd1);
    prog[8] = i_ldwi(4'hB);  prog[9] = i_stwr(5'd10);
    prog[10] = i_alu(O_RRR, 1'b1, 5'd10); prog[11] = i_alu(O_RRR, 1'b0, 5'd10);
    prog[12] = i_stwr(5'd5); prog[13] = i_ldwi(4'h3);
    prog[14] = i_alu(O_ADD, 1'b1, 5'd10); prog[15] = i_stwr(5'd6);
    prog[16] = i_alu(O_LDR, 1'b0, 5'd10); prog[17] = i_imm(4'b0010, 4'hE);
    prog[18] = i_imm(4'b0110, 4'h3); prog[19] = i_imm(4'b0000, 4'h3);
    prog[20] = i_stwr(5'd7); prog[21] = i_jmp(9'd21);
    run(50);
    chk("R7 and/xor to register, or to W", ext_mem[1], 4'h2);
    chk("R9 rotate right twice", ext_mem[5], 4'h2);
    chk("R7 add t=1 leaves W", ext_mem[6], 4'h3);
    chk("R14 immediate and/or, no-op code", ext_mem[7], 4'hB);
  endtask

  task automatic t_bits_skip();
    clear_prog();
    prog[0] = i_ldwi(4'h0);  prog[1] = i_stwr(5'd11);
    prog[2] = i_bit(1'b1, 1'b0, 2'd3, 5'd11); prog[3] = i_bit(1'b1, 1'b0, 2'd0, 5'd11);
    prog[4] = i_bit(1'b0, 1'b0, 2'd3, 5'd11); prog[5] = i_alu(O_LDR, 1'b0, 5'd11);
    prog[6] = i_stwr(5'd1);
    prog[7] = i_bit(1'b1, 1'b1, 2'd0, 5'd11); prog[8] = i_ldwi(4'hF);
    prog[9] = i_stwr(5'd5);
    prog[10] = i_bit(1'b0, 1'b1, 2'd1, 5'd11); prog[11] = i_ldwi(4'hE);
    prog[12] = i_stwr(5'd6);
    prog[13] = i_bit(1'b1, 1'b1, 2'd1, 5'd11); prog[14] = i_ldwi(4'h4);
    prog[15] = i_stwr(5'd7);
    prog[16] = i_bit(1'b0, 1'b1, 2'd1, 5'd11); prog[17] = i_stwr(5'd1);
    prog[18] = i_jmp(9'd18);
    run(50);
    chk("R11 set/clear bits, R12 skipped store", ext_mem[1], 4'h1);
    chk("R11 test-set skips", ext_mem[5], 4'h1);
    chk("R11 test-clear skips", ext_mem[6], 4'h1);
    chk("R11 test-set no skip", ext_mem[7], 4'h4);
  endtask

  task automatic t_decrement();
    clear_prog();
    prog[0] = i_ldwi(4'h9);  prog[1] = i_stwr(5'd8);
    prog[2] = i_ldwi(4'h8);  prog[3] = i_alu(O_ADD, 1'b0, 5'd8);
    prog[4] = i_ldwi(4'h3);  prog[5] = i_stwr(5'd12);
    prog[6] = i_alu(O_DEC, 1'b1, 5'd12); prog[7] = i_jmp(9'd6);
    prog[8] = i_alu(O_LDR, 1'b0, 5'd3);  prog[9] = i_stwr(5'd5);
    prog[10] = i_alu(O_LDR, 1'b0, 5'd12); prog[11] = i_stwr(5'd6);
    prog[12] = i_ldwi(4'h1); prog[13] = i_stwr(5'd13);
    prog[14] = i_alu(O_DEC, 1'b0, 5'd13); prog[15] = i_ldwi(4'h9);
    prog[16] = i_stwr(5'd7); prog[17] = i_alu(O_LDR, 1'b0, 5'd13);
    prog[18] = i_stwr(5'd1); prog[19] = i_jmp(9'd19);
    run(60);
    chk("R10 decrement leaves flags", ext_mem[5], 4'h2);
    chk("R10 loop exits at zero", ext_mem[6], 4'h0);
    chk("R10 dec to W skips", ext_mem[7], 4'h0);
    chk("R10 dec t=0 keeps register", ext_mem[1], 4'h1);
  endtask

  task automatic t_call_return();
    clear_prog();
    prog[0] = i_bit(1'b1, 1'b0, 2'd2, 5'd4); prog[1] = i_jmp(9'd10);
    prog[2] = i_stwr(5'd5); prog[3] = i_alu(O_LDR, 1'b0, 5'd4);
    prog[4] = i_stwr(5'd6); prog[5] = i_jmp(9'd5);
    prog[10] = i_bit(1'b1, 1'b0, 2'd2, 5'd4); prog[11] = i_jmp(9'd20);
    prog[12] = i_stwr(5'd7); prog[13] = i_ret(4'h7);
    prog[20] = i_ret(4'h3);
    run(40);
    chk("R5 outer return immediate", ext_mem[5], 4'h7);
    chk("R4 call mode cleared", ext_mem[6], 4'h0);
    chk("R5 inner return immediate", ext_mem[7], 4'h3);
  endtask

  task automatic t_stack_overflow();
    clear_prog();
    prog[0] = i_bit(1'b1, 1'b0, 2'd2, 5'd4); prog[1] = i_jmp(9'd10);
    prog[2] = i_stwr(5'd5); prog[3] = i_jmp(9'd3);
    prog[10] = i_bit(1'b1, 1'b0, 2'd2, 5'd4); prog[11] = i_jmp(9'd20);
    prog[12] = i_stwr(5'd6); prog[13] = i_ret(4'h2);
    prog[20] = i_bit(1'b1, 1'b0, 2'd2, 5'd4); prog[21] = i_jmp(9'd30);
    prog[22] = i_ret(4'h9);
    prog[30] = i_ret(4'h4);
    run(40);
    chk("R6 oldest return lost", ext_mem[5], 4'hF);
    chk("R6 lower entry kept after pop", ext_mem[6], 4'h2);
  endtask

  task automatic t_reg_map();
    clear_prog();
    prog[0] = i_ldwi(4'h6);  prog[1] = i_stwr(5'd2);
    prog[2] = i_ldwi(4'hF);  prog[3] = i_stwr(5'd5);
    prog[6] = i_ldwi(4'h5);  prog[7] = i_stwr(5'd5);
    prog[8] = i_alu(O_LDR, 1'b0, 5'd2); prog[9] = i_stwr(5'd6);
    prog[10] = i_alu(O_LDR, 1'b0, 5'd0); prog[11] = i_stwr(5'd7);
    prog[12] = i_alu(O_LDR, 1'b0, 5'd1); prog[13] = i_imm(4'b0100, 4'h5);
    prog[14] = i_stwr(5'd1); prog[15] = i_jmp(9'd15);
    run(40);
    chk("R13 pc-low write redirects", ext_mem[5], 4'h5);
    chk("R13 pc-low read", ext_mem[6], 4'h8);
    chk("R13 address 0 reads 0", ext_mem[7], 4'h0);
    chk("R13 external read/write", ext_mem[1], 4'hA);
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = i_stwr(5'd5); prog[1] = i_alu(O_LDR, 1'b0, 5'd3);
    prog[2] = i_stwr(5'd6); prog[3] = i_alu(O_LDR, 1'b0, 5'd4);
    prog[4] = i_stwr(5'd7); prog[5] = i_jmp(9'd5);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fetch address in reset", imem_addr, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2 sequential fetch", imem_addr, 1);
    repeat (10) @(posedge clk); #1;
    chk("R3 jump to self", imem_addr, 5);
    chk("R1 W reset", ext_mem[5], 4'h0);
    chk("R1 flags reset", ext_mem[6], 4'h0);
    chk("R1 call mode reset", ext_mem[7], 4'h0);
  endtask

  initial begin
    t_alu_flags();
    t_reset();
    t_logic_rotate();
    t_bits_skip();
    t_decrement();
    t_call_return();
    t_stack_overflow();
    t_reg_map();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule